// File: doc/BRIEF.md
# Delayed-Load Commit and PC Sequencer

This block holds the architectural program-counter triple of a scalar core (the previous PC, the current PC and the next PC) and a one-entry slot for a load whose result becomes visible one instruction late. Each time an instruction retires, three things happen. The load parked in the slot is written to the register file. The retiring instruction's own load result takes its place in the slot. The PC triple shifts forward by one, with a freshly computed follow-on address entering at the tail.

Branches and jumps are resolved against the next PC, not the current one. This gives the one-instruction delay slot that the surrounding core expects. Link forms return the address just past the delay slot.

An exception abort discards everything the current instruction would have done, except that the parked load is still written back, so the register file is complete before the trap is taken. Fetch, decode and the ALU live elsewhere. This block only sees their verdicts: the retire strobe, the control-flow kind with its operands, and the new load destination and value.

Top module: `pc_ldcommit_seq`

## Requirements
- R1: While reset is held, and afterwards until the first strobe, the outputs are as follows: PC and previous PC equal RESET_PC, the next PC equals RESET_PC+4, the load slot is empty, and neither write port is enabled.
- R2: A retire (done_i=1, abort_i=0) with flow_i=0 (sequential) makes previous PC take PC, PC take next PC, and next PC take next PC+4, all visible after the clock edge.
- R3: With flow_i=1 (conditional branch), a retire with taken_i=1 sets the new next PC to the old next PC plus the sign-extended 16-bit offset_i shifted left by 2. With taken_i=0 the new next PC is the old next PC+4.
- R4: With flow_i=2 (absolute jump), the new next PC keeps the top 4 bits of (old next PC+4) and fills the rest with the 26-bit jidx_i shifted left by 2.
- R5: With flow_i=3 (register jump), the new next PC is jreg_i unchanged.
- R6: A retire with link_i=1 drives the link port in the same cycle, with value old next PC+4. The target register is link_rd_i for flow_i=3 and register 31 for every other kind.
- R7: On a retire, the load port presents the parked (index, value) in the same cycle, and the slot then holds ld_idx_i/ld_val_i from that instruction. Index 0 means "no load".
- R8: Register 0 is never written: a parked load to index 0, or a link target of 0, enables no port.
- R9: When abort_i=1, whatever done_i is: the PCs hold, the link port stays off, the new load is dropped, and the parked load is still written out with the slot emptied afterwards.
- R10: If the load port and the link port target the same register in one cycle, only the load write is enabled, so the parked load wins.
- R11: With done_i=0 and abort_i=0, neither port is enabled and the PCs and slot keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Instruction retire strobe |
| abort_i | input | 1 | Exception abort for the current instruction |
| flow_i | input | 2 | Flow kind: 0 seq, 1 branch, 2 absolute jump, 3 register jump |
| taken_i | input | 1 | Branch condition result |
| link_i | input | 1 | Instruction writes a return address |
| link_rd_i | input | RIDX_W | Link destination for register-jump form |
| offset_i | input | 16 | Branch word offset |
| jidx_i | input | XLEN-6 | Absolute jump word index |
| jreg_i | input | XLEN | Register jump target |
| ld_idx_i | input | RIDX_W | Destination of the retiring instruction's load (0 = none) |
| ld_val_i | input | XLEN | Value of that load |
| ld_we_o | output | 1 | Load write enable |
| ld_widx_o | output | RIDX_W | Load write index |
| ld_wval_o | output | XLEN | Load write data |
| lk_we_o | output | 1 | Link write enable |
| lk_widx_o | output | RIDX_W | Link write index |
| lk_wval_o | output | XLEN | Link write data |
| ppc_o | output | XLEN | Previous PC |
| pc_o | output | XLEN | Current PC |
| npc_o | output | XLEN | Next PC |

## Verification
Both write ports are combinational from the slot register and the strobe inputs, so their results are due in the same cycle as the stimulus. The PC triple and the slot contents are due one clock edge later. The scoreboard follows this split. For each driven cycle it queues one expected entry. The monitor checks the write-port part of that entry mid-cycle, before the next edge, and keeps the PC part back to compare one cycle later. A slot refill is therefore only seen through the write port of the following retire or abort, which is where the checks look for it.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_BR   = 2'd1,
        FLOW_JABS = 2'd2,
        FLOW_JREG = 2'd3
    } flow_e;

    localparam int OFF_W   = 16;
    localparam int INSN_B  = 4;
endpackage

// File: rtl/pcs_target.sv
`timescale 1ns/1ps
module pcs_target
    import pcs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   npc_i,
    input  flow_e             flow_i,
    input  logic              taken_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [XLEN-7:0]   jidx_i,
    input  logic [XLEN-1:0]   jreg_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   nnpc_o
);
    localparam int SEXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] br_disp;

    always_comb begin
        seq_o   = npc_i + XLEN'(INSN_B);
        br_disp = {{SEXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
        unique case (flow_i)
            FLOW_BR:   nnpc_o = taken_i ? (npc_i + br_disp) : seq_o;
            FLOW_JABS: nnpc_o = {seq_o[XLEN-1:XLEN-4], jidx_i, 2'b00};
            FLOW_JREG: nnpc_o = jreg_i;
            default:   nnpc_o = seq_o;
        endcase
    end
endmodule

// File: rtl/pcs_wb.sv
`timescale 1ns/1ps
module pcs_wb
    import pcs_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic              commit_i,
    input  logic              retire_i,
    input  logic [RIDX_W-1:0] pend_idx_i,
    input  logic [XLEN-1:0]   pend_val_i,
    input  logic              link_i,
    input  flow_e             flow_i,
    input  logic [RIDX_W-1:0] link_rd_i,
    input  logic [XLEN-1:0]   link_val_i,
    output logic              ld_we_o,
    output logic [RIDX_W-1:0] ld_idx_o,
    output logic [XLEN-1:0]   ld_val_o,
    output logic              lk_we_o,
    output logic [RIDX_W-1:0] lk_idx_o,
    output logic [XLEN-1:0]   lk_val_o
);
    logic lk_clash;

    always_comb begin
        ld_idx_o = pend_idx_i;
        ld_val_o = pend_val_i;
        ld_we_o  = commit_i && (pend_idx_i != '0);

        lk_idx_o = (flow_i == FLOW_JREG) ? link_rd_i : RIDX_W'(LINK_REG);
        lk_val_o = link_val_i;
        lk_clash = ld_we_o && (lk_idx_o == pend_idx_i);
        lk_we_o  = retire_i && link_i && (lk_idx_o != '0) && !lk_clash;
    end
endmodule

// File: rtl/pc_ldcommit_seq.sv
`timescale 1ns/1ps
module pc_ldcommit_seq
    import pcs_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    parameter int          RIDX_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              abort_i,
    input  logic [1:0]        flow_i,
    input  logic              taken_i,
    input  logic              link_i,
    input  logic [RIDX_W-1:0] link_rd_i,
    input  logic [15:0]       offset_i,
    input  logic [XLEN-7:0]   jidx_i,
    input  logic [XLEN-1:0]   jreg_i,
    input  logic [RIDX_W-1:0] ld_idx_i,
    input  logic [XLEN-1:0]   ld_val_i,
    output logic              ld_we_o,
    output logic [RIDX_W-1:0] ld_widx_o,
    output logic [XLEN-1:0]   ld_wval_o,
    output logic              lk_we_o,
    output logic [RIDX_W-1:0] lk_widx_o,
    output logic [XLEN-1:0]   lk_wval_o,
    output logic [XLEN-1:0]   ppc_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   npc_o
);
    localparam logic [XLEN-1:0] PC0  = XLEN'(RESET_PC);
    localparam logic [XLEN-1:0] NPC0 = PC0 + XLEN'(INSN_B);

    typedef struct packed {
        logic [XLEN-1:0]   ppc;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   npc;
        logic [RIDX_W-1:0] pd_idx;
        logic [XLEN-1:0]   pd_val;
    } seq_st_t;

    seq_st_t st_d, st_q;
    flow_e   flow;
    logic    retire, commit;
    logic [XLEN-1:0] seq_pc, nnpc;

    assign flow   = flow_e'(flow_i);
    assign retire = done_i && !abort_i;
    assign commit = done_i || abort_i;

    pcs_target #(.XLEN(XLEN)) u_target (
        .npc_i    (st_q.npc),
        .flow_i   (flow),
        .taken_i  (taken_i),
        .offset_i (offset_i),
        .jidx_i   (jidx_i),
        .jreg_i   (jreg_i),
        .seq_o    (seq_pc),
        .nnpc_o   (nnpc)
    );

    pcs_wb #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(NREG-1)) u_wb (
        .commit_i   (commit),
        .retire_i   (retire),
        .pend_idx_i (st_q.pd_idx),
        .pend_val_i (st_q.pd_val),
        .link_i     (link_i),
        .flow_i     (flow),
        .link_rd_i  (link_rd_i),
        .link_val_i (seq_pc),
        .ld_we_o    (ld_we_o),
        .ld_idx_o   (ld_widx_o),
        .ld_val_o   (ld_wval_o),
        .lk_we_o    (lk_we_o),
        .lk_idx_o   (lk_widx_o),
        .lk_val_o   (lk_wval_o)
    );

    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d.pd_idx = '0;
            st_d.pd_val = '0;
        end else if (done_i) begin
            st_d.ppc    = st_q.pc;
            st_d.pc     = st_q.npc;
            st_d.npc    = nnpc;
            st_d.pd_idx = ld_idx_i;
            st_d.pd_val = ld_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ppc    <= PC0;
            st_q.pc     <= PC0;
            st_q.npc    <= NPC0;
            st_q.pd_idx <= '0;
            st_q.pd_val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ppc_o = st_q.ppc;
    assign pc_o  = st_q.pc;
    assign npc_o = st_q.npc;
endmodule

// File: rtl/pcs_chk.sv
`timescale 1ns/1ps
module pcs_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic              abort_i,
    input logic [1:0]        flow_i,
    input logic              ld_we_o,
    input logic [RIDX_W-1:0] ld_widx_o,
    input logic              lk_we_o,
    input logic [RIDX_W-1:0] lk_widx_o,
    input logic [XLEN-1:0]   lk_wval_o,
    input logic [XLEN-1:0]   ppc_o,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   npc_o
);
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !abort_i) |=> (pc_o == $past(npc_o)) && (ppc_o == $past(pc_o))); // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !abort_i && flow_i == 2'd0) |=> (npc_o == $past(npc_o) + XLEN'(4))); // R2
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_we_o |-> (lk_wval_o == npc_o + XLEN'(4))); // R6
    AST_LD_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we_o |-> (ld_widx_o != '0)); // R8
    AST_LK_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n)
        lk_we_o |-> (lk_widx_o != '0)); // R8
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> $stable(pc_o) && $stable(npc_o) && $stable(ppc_o)); // R9
    AST_ABORT_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !lk_we_o); // R9
    AST_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we_o && lk_we_o) |-> (ld_widx_o != lk_widx_o)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_i || abort_i) |-> (!ld_we_o && !lk_we_o)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_i || abort_i) |=> $stable(pc_o) && $stable(npc_o) && $stable(ppc_o)); // R11
endmodule

bind pc_ldcommit_seq pcs_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (done_i),
    .abort_i   (abort_i),
    .flow_i    (flow_i),
    .ld_we_o   (ld_we_o),
    .ld_widx_o (ld_widx_o),
    .lk_we_o   (lk_we_o),
    .lk_widx_o (lk_widx_o),
    .lk_wval_o (lk_wval_o),
    .ppc_o     (ppc_o),
    .pc_o      (pc_o),
    .npc_o     (npc_o)
);

// File: tb/test_pc_ldcommit_seq.sv
`timescale 1ns/1ps
module test_pc_ldcommit_seq;
    localparam int          XLEN = 32;
    localparam int          RW   = 5;
    localparam logic [31:0] RPC  = 32'h0000_1000;

    typedef struct packed {
        logic            ld_we;
        logic [RW-1:0]   ld_idx;
        logic [XLEN-1:0] ld_val;
        logic            lk_we;
        logic [RW-1:0]   lk_idx;
        logic [XLEN-1:0] lk_val;
        logic [XLEN-1:0] ppc;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic done_i = 0, abort_i = 0, taken_i = 0, link_i = 0;
    logic [1:0] flow_i = 0;
    logic [RW-1:0] link_rd_i = 0, ld_idx_i = 0;
    logic [15:0] offset_i = 0;
    logic [XLEN-7:0] jidx_i = 0;
    logic [XLEN-1:0] jreg_i = 0, ld_val_i = 0;
    logic ld_we_o, lk_we_o;
    logic [RW-1:0] ld_widx_o, lk_widx_o;
    logic [XLEN-1:0] ld_wval_o, lk_wval_o, ppc_o, pc_o, npc_o;

    int n_run = 0, n_fail = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [XLEN-1:0] m_ppc = RPC, m_pc = RPC, m_npc = RPC + 4;
    logic [RW-1:0]   m_pi = 0;
    logic [XLEN-1:0] m_pv = 0;
    logic stim_done = 0;

    always #10 clk = ~clk;

    pc_ldcommit_seq #(.XLEN(XLEN), .NREG(32), .RESET_PC(RPC)) i_pc_ldcommit_seq (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .abort_i(abort_i),
        .flow_i(flow_i), .taken_i(taken_i), .link_i(link_i), .link_rd_i(link_rd_i),
        .offset_i(offset_i), .jidx_i(jidx_i), .jreg_i(jreg_i),
        .ld_idx_i(ld_idx_i), .ld_val_i(ld_val_i),
        .ld_we_o(ld_we_o), .ld_widx_o(ld_widx_o), .ld_wval_o(ld_wval_o),
        .lk_we_o(lk_we_o), .lk_widx_o(lk_widx_o), .lk_wval_o(lk_wval_o),
        .ppc_o(ppc_o), .pc_o(pc_o), .npc_o(npc_o)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp,
                         input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic d, input logic ab, input logic [1:0] fl,
                        input logic tk, input logic lk, input logic [RW-1:0] lrd,
                        input logic [15:0] off, input logic [XLEN-7:0] ji,
                        input logic [XLEN-1:0] jr, input logic [RW-1:0] li,
                        input logic [XLEN-1:0] lv);
        exp_t e;
        logic [XLEN-1:0] seq, nn;
        logic commit, retire;
        @(negedge clk);
        done_i = d; abort_i = ab; flow_i = fl; taken_i = tk; link_i = lk;
        link_rd_i = lrd; offset_i = off; jidx_i = ji; jreg_i = jr;
        ld_idx_i = li; ld_val_i = lv;
        commit = d || ab;
        retire = d && !ab;
        seq = m_npc + 4;
        case (fl)
            2'd1:    nn = tk ? m_npc + {{14{off[15]}}, off, 2'b00} : seq;
            2'd2:    nn = {seq[31:28], ji, 2'b00};
            2'd3:    nn = jr;
            default: nn = seq;
        endcase
        e.ld_we  = commit && (m_pi != 0);
        e.ld_idx = m_pi;
        e.ld_val = m_pv;
        e.lk_idx = (fl == 2'd3) ? lrd : 5'd31;
        e.lk_val = seq;
        e.lk_we  = retire && lk && (e.lk_idx != 0) && !(e.ld_we && e.lk_idx == m_pi);
        if (ab) begin
            m_pi = 0; m_pv = 0;
        end else if (d) begin
            m_ppc = m_pc; m_pc = m_npc; m_npc = nn;
            m_pi = li; m_pv = lv;
        end
        e.ppc = m_ppc; e.pc = m_pc; e.npc = m_npc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // monitor: write ports mid-cycle, PCs one cycle later
    initial begin
        exp_t  pend_e;
        string pend_t;
        logic  have = 0;
        forever begin
            @(negedge clk);
            #5;
            if (have) begin
                check(pend_t, 128'(ppc_o), 128'(pend_e.ppc), "ppc");
                check(pend_t, 128'(pc_o),  128'(pend_e.pc),  "pc");
                check(pend_t, 128'(npc_o), 128'(pend_e.npc), "npc");
                have = 0;
            end
            if (exp_q.size() > 0) begin
                pend_e = exp_q.pop_front();
                pend_t = tag_q.pop_front();
                check(pend_t, 128'(ld_we_o), 128'(pend_e.ld_we), "ld_we");
                if (pend_e.ld_we) begin
                    check(pend_t, 128'(ld_widx_o), 128'(pend_e.ld_idx), "ld_idx");
                    check(pend_t, 128'(ld_wval_o), 128'(pend_e.ld_val), "ld_val");
                end
                check(pend_t, 128'(lk_we_o), 128'(pend_e.lk_we), "lk_we");
                if (pend_e.lk_we) begin
                    check(pend_t, 128'(lk_widx_o), 128'(pend_e.lk_idx), "lk_idx");
                    check(pend_t, 128'(lk_wval_o), 128'(pend_e.lk_val), "lk_val");
                end
                have = 1;
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R1", 128'(pc_o), 128'(RPC), "pc in reset");
        check("R1", 128'(npc_o), 128'(RPC + 4), "npc in reset");
        check("R1", 128'({ld_we_o, lk_we_o}), 128'(0), "we in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd5, 32'hA5A5_0001);
        step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd0, 0);
        step("R3", 1, 0, 1, 1, 0, 0, 16'h0010, 0, 0, 5'd7, 32'h0000_0777);
        step("R3", 1, 0, 1, 0, 0, 0, 16'h0040, 0, 0, 5'd0, 0);
        step("R3", 1, 0, 1, 1, 0, 0, 16'hFFF0, 0, 0, 5'd0, 0);
        step("R4", 1, 0, 2, 0, 1, 0, 0, 26'h004_0000, 0, 5'd3, 32'h3333_3333);
        step("R5", 1, 0, 3, 0, 1, 5'd9, 0, 0, 32'h2000_0100, 5'd0, 0);
        step("R8", 1, 0, 3, 0, 1, 5'd0, 0, 0, 32'h2000_0200, 5'd12, 32'hC0DE_000C);
        idle("R11");
        idle("R11");
        step("R9", 0, 1, 2, 0, 1, 0, 0, 26'h3FF_FFFF, 0, 5'd14, 32'hDEAD_BEEF);
        step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd31, 32'h1F1F_1F1F);
        step("R10", 1, 0, 2, 0, 1, 0, 0, 26'h000_0100, 0, 5'd0, 0);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd0, 32'h0BAD_0000);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd6, 32'h6666_0006);
        step("R9", 1, 1, 1, 1, 1, 0, 16'h0100, 0, 0, 5'd8, 32'h8888_8888);
        step("R6", 1, 0, 1, 1, 1, 0, 16'h0002, 0, 0, 5'd0, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd0, 0);
        idle("R11");
        repeat (3) @(negedge clk);
        stim_done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule